// File: doc/BRIEF.md
# Interrupt Flag Controller for an 8-bit Microcontroller Core

This block collects three interrupt sources for a small 8-bit core. The first is an external pin whose active edge is picked by an option input. The second is a one-cycle timer overflow pulse. The third is a detector that watches the upper four pins of an input port for any change. Each source has a sticky flag and an enable bit. These sit in one 8-bit control register that software reads and writes, together with a global enable. Hardware only ever sets the flags. Software clears them by writing zeros.

Two outputs go to the core. The interrupt request is the global enable ANDed with any enabled pending flag. The wake output serves a sleeping core. It uses the enables that were in force when sleep began and ignores the global enable. The global enable only decides whether the woken core takes the vector. The port-change detector compares the synchronized pins against a copy that is reloaded on every port read. A change that lands in the same cycle as such a read is absorbed by the reload and raises no flag.

Top module: `irq_flag_ctl`

## Requirements
- R1: After reset the control register reads 8'h00, and both the request and the wake outputs are 0.
- R2: With the edge-select input at 1, a 0-to-1 transition on the external pin sets register bit 1. The flag becomes visible after the third rising clock edge that follows the pin change, and not after the second. A 1-to-0 transition leaves the flag clear.
- R3: With the edge-select input at 0, a 1-to-0 transition on the external pin sets bit 1, and a 0-to-1 transition leaves it clear.
- R4: A one-cycle overflow pulse sets bit 2, and the flag is visible after the clock edge that samples the pulse.
- R5: When the synchronized port pins differ from the copy taken at the last port read, bit 0 is set. A port read reloads that copy, so after the read and a software clear the bit stays 0.
- R6: If the synchronized pins first show a new value in the same cycle that the read strobe is sampled, the read reloads the copy and bit 0 is not set.
- R7: The register layout is: bit 7 global enable, bit 6 reads 0, bit 5 timer enable, bit 4 external enable, bit 3 port enable, bit 2 timer flag, bit 1 external flag, bit 0 port flag. A write stores every bit except bit 6. Flags keep their value until software writes them.
- R8: A hardware set event in the same cycle as a software write of 0 to that flag leaves the flag at 1.
- R9: The request output equals bit 7 AND ((bit 0 AND bit 3) OR (bit 1 AND bit 4) OR (bit 2 AND bit 5)).
- R10: The wake output equals the sleep input AND the OR over the three sources of (flag AND enable). The enables used are those held in the last cycle before sleep was asserted. The wake output does not depend on bit 7, and enables written during sleep do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| edgeRise | input | 1 | External pin edge select: 1 rising, 0 falling |
| extPin | input | 1 | External interrupt pin (asynchronous) |
| portHi | input | 4 | Upper four port pins (asynchronous) |
| tmrOvf | input | 1 | One-cycle timer overflow pulse |
| portRead | input | 1 | Port read strobe; reloads the change-detect copy |
| sleeping | input | 1 | Core is asleep |
| ctlWrEn | input | 1 | Control register write enable |
| ctlWrData | input | 8 | Control register write data |
| ctlRdData | output | 8 | Control register read value |
| irqReq | output | 1 | Interrupt request to the core |
| wakeReq | output | 1 | Wake-up request to a sleeping core |

## Verification
The bench sweeps every control register value and checks the read-back and the request output. A design that lets bit 6 be written, or pairs a flag with the wrong enable, fails here. It also sweeps all enable and flag pairs under sleep with the global enable off. A design that gates wake with the global enable, or follows enables written during sleep, would report a wake that should not happen, or miss one. It places a port read in exactly the cycle the synchronized pins change. A design that gives the change priority would set the port flag there. Further checks cover the pin latency, the opposite edge that must be ignored, and a write of 0 that meets a timer pulse. A design that lets the write win would clear the timer flag.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int PORT_W = 4;
  localparam int SRC_N  = 3;

  // Per-source set strobes from control to datapath
  typedef struct packed {
    logic tmrSet;
    logic extSet;
    logic portSet;
  } setStb_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int PW          = PORT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          edgeRise,
  input  logic          extPin,
  input  logic [PW-1:0] portHi,
  input  logic          tmrOvf,
  input  logic          portRead,
  output setStb_t       setStb
);
  localparam int SW = PW + 1;

  logic [SW-1:0] syncOut;
  logic          extNow;
  logic          extPrev;
  logic [PW-1:0] portNow;
  logic [PW-1:0] portLatch;

  irq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({extPin, portHi}),
    .dout (syncOut)
  );

  assign extNow  = syncOut[SW-1];
  assign portNow = syncOut[PW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev   <= 1'b0;
      portLatch <= '0;
    end else begin
      extPrev <= extNow;
      if (portRead) portLatch <= portNow;
    end
  end

  // Edge picked by option input; read relatch beats a coincident change
  always_comb begin
    setStb.extSet  = edgeRise ? (extNow & ~extPrev) : (~extNow & extPrev);
    setStb.tmrSet  = tmrOvf;
    setStb.portSet = (portNow != portLatch) && !portRead;
  end

  AST_RISE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    (setStb.extSet && edgeRise) |=> !(setStb.extSet && edgeRise)); // R2

  AST_READ_RELATCH: assert property (@(posedge clk) disable iff (!rstN)
    portRead |=> (portLatch == $past(portNow))); // R6
endmodule

// File: rtl/irq_flag_dp.sv
module irq_flag_dp
  import irq_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  setStb_t    setStb,
  input  logic       ctlWrEn,
  input  logic [7:0] ctlWrData,
  input  logic       sleeping,
  output logic [7:0] ctlRdData,
  output logic       irqReq,
  output logic       wakeReq
);
  logic             globalEn;
  logic [SRC_N-1:0] enQ;
  logic [SRC_N-1:0] flagQ;
  logic [SRC_N-1:0] sleepMask;
  logic [SRC_N-1:0] hwSet;
  logic [SRC_N-1:0] flagNext;

  // Bit order {timer, external, port} matches enables at 5:3 and flags at 2:0
  assign hwSet    = setStb;
  assign flagNext = (ctlWrEn ? ctlWrData[SRC_N-1:0] : flagQ) | hwSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn  <= 1'b0;
      enQ       <= '0;
      flagQ     <= '0;
      sleepMask <= '0;
    end else begin
      flagQ <= flagNext;
      if (ctlWrEn) begin
        globalEn <= ctlWrData[7];
        enQ      <= ctlWrData[5:3];
      end
      if (!sleeping) sleepMask <= enQ;
    end
  end

  assign ctlRdData = {globalEn, 1'b0, enQ, flagQ};
  assign irqReq    = globalEn & |(flagQ & enQ);
  assign wakeReq   = sleeping & |(flagQ & sleepMask);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrEn |=> ((flagQ & $past(flagQ)) == $past(flagQ))); // R7

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|hwSet) |=> ((flagQ & $past(hwSet)) == $past(hwSet))); // R8

  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> ($past(ctlWrEn) || $past(|hwSet))); // R9

  AST_WAKE_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (sleeping && $past(sleeping)) |-> $stable(sleepMask)); // R10
endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl
  import irq_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              edgeRise,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portHi,
  input  logic              tmrOvf,
  input  logic              portRead,
  input  logic              sleeping,
  input  logic              ctlWrEn,
  input  logic [7:0]        ctlWrData,
  output logic [7:0]        ctlRdData,
  output logic              irqReq,
  output logic              wakeReq
);
  setStb_t setStb;

  irq_flag_ctrl #(.PW(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .edgeRise (edgeRise),
    .extPin   (extPin),
    .portHi   (portHi),
    .tmrOvf   (tmrOvf),
    .portRead (portRead),
    .setStb   (setStb)
  );

  irq_flag_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .setStb    (setStb),
    .ctlWrEn   (ctlWrEn),
    .ctlWrData (ctlWrData),
    .sleeping  (sleeping),
    .ctlRdData (ctlRdData),
    .irqReq    (irqReq),
    .wakeReq   (wakeReq)
  );
endmodule

// File: tb/irq_flag_ctl_bench.sv
module irq_flag_ctl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       edgeRise = 1'b1;
  logic       extPin = 1'b0;
  logic [3:0] portHi = 4'h0;
  logic       tmrOvf = 1'b0;
  logic       portRead = 1'b0;
  logic       sleeping = 1'b0;
  logic       ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = 8'h00;
  logic [7:0] ctlRdData;
  logic       irqReq;
  logic       wakeReq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_flag_ctl u_irq_flag_ctl (
    .clk(clk), .rstN(rstN), .edgeRise(edgeRise), .extPin(extPin),
    .portHi(portHi), .tmrOvf(tmrOvf), .portRead(portRead),
    .sleeping(sleeping), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .irqReq(irqReq), .wakeReq(wakeReq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    ctlWrEn = 1'b1;
    ctlWrData = d;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk("R1 reg", ctlRdData, 8'h00);
    chk("R1 irq", {7'd0, irqReq}, 8'h00);
    chk("R1 wake", {7'd0, wakeReq}, 8'h00);

    // R7 / R9 sweep over every register value
    for (int w = 0; w < 256; w++) begin
      logic [7:0] v;
      v = 8'(w);
      wr(v);
      chk("R7 readback", ctlRdData, v & 8'hBF);
      chk("R9 irq", {7'd0, irqReq}, {7'd0, v[7] & |(v[2:0] & v[5:3])});
    end
    wr(8'h00);

    // R10 sweep: enables and flags under sleep, global enable off
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 8; f++) begin
        logic [2:0] ee, ff;
        ee = 3'(e);
        ff = 3'(f);
        wr({2'b00, ee, ff});
        tick(1);
        sleeping = 1'b1;
        tick(1);
        chk("R10 wake", {7'd0, wakeReq}, {7'd0, |(ee & ff)});
        sleeping = 1'b0;
      end
    end
    wr(8'h00);

    // R10 enable written during sleep does not count
    wr(8'h02);
    tick(1);
    sleeping = 1'b1;
    wr(8'h92);
    chk("R10 frozen", {7'd0, wakeReq}, 8'h00);
    sleeping = 1'b0;
    tick(1);
    sleeping = 1'b1;
    wr(8'h12);
    chk("R10 wake no gie", {7'd0, wakeReq}, 8'h01);
    sleeping = 1'b0;
    wr(8'h00);

    // R2 rising edge, latency and ignored falling edge
    edgeRise = 1'b1;
    extPin = 1'b1;
    tick(2);
    chk("R2 latency", {7'd0, ctlRdData[1]}, 8'h00);
    tick(1);
    chk("R2 rise", {7'd0, ctlRdData[1]}, 8'h01);
    wr(8'h00);
    extPin = 1'b0;
    tick(4);
    chk("R2 fall ignored", {7'd0, ctlRdData[1]}, 8'h00);

    // R3 falling edge mode
    edgeRise = 1'b0;
    extPin = 1'b1;
    tick(4);
    chk("R3 rise ignored", {7'd0, ctlRdData[1]}, 8'h00);
    extPin = 1'b0;
    tick(4);
    chk("R3 fall", {7'd0, ctlRdData[1]}, 8'h01);
    wr(8'h00);
    edgeRise = 1'b1;

    // R4 timer pulse, R7 stickiness and clear
    chk("R4 before", {7'd0, ctlRdData[2]}, 8'h00);
    tmrOvf = 1'b1;
    tick(1);
    tmrOvf = 1'b0;
    chk("R4 overflow", {7'd0, ctlRdData[2]}, 8'h01);
    tick(10);
    chk("R7 sticky", {7'd0, ctlRdData[2]}, 8'h01);
    wr(8'h00);
    chk("R7 clear", ctlRdData, 8'h00);

    // R8 hardware set beats software clear
    ctlWrEn = 1'b1;
    ctlWrData = 8'h00;
    tmrOvf = 1'b1;
    tick(1);
    ctlWrEn = 1'b0;
    tmrOvf = 1'b0;
    chk("R8 hw wins", {7'd0, ctlRdData[2]}, 8'h01);
    wr(8'h00);

    // R5 port change, read relatch, clear
    portHi = 4'h5;
    tick(4);
    chk("R5 change", {7'd0, ctlRdData[0]}, 8'h01);
    portRead = 1'b1;
    tick(1);
    portRead = 1'b0;
    wr(8'h00);
    tick(3);
    chk("R5 relatched", ctlRdData, 8'h00);

    // R6 change coinciding with read is lost
    portHi = 4'hA;
    tick(2);
    portRead = 1'b1;
    tick(1);
    portRead = 1'b0;
    tick(3);
    chk("R6 lost change", {7'd0, ctlRdData[0]}, 8'h00);
    portHi = 4'h3;
    tick(4);
    chk("R5 later change", {7'd0, ctlRdData[0]}, 8'h01);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule